// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block forms a 20-bit physical byte address from a 16-bit segment value and a 16-bit offset. It holds four 16-bit segment registers: data, code, stack and extra. A write port loads them one at a time. The segment value is moved four bit positions to the left, and the offset is added to the result.

Each request says what kind of reference it is. The kinds are a general or index-register data access, an instruction fetch, a stack-pointer or base-pointer access, and a string-operation destination. From that kind the block picks a default segment. A segment-override input can replace the default, but only for data and stack references.

The physical address and a 2-bit code for the segment actually used come out of registers. They appear one cycle after the request.

Top module: `seg_addr_gen`

## Requirements
- R1: While `rst_ni` is low and after its release, `addr_valid_o` is 0, `addr_o` is 0, `seg_used_o` is 0, and all four segment registers hold 0.
- R2: A request accepted at a clock edge produces, at that same edge, `addr_valid_o`=1 and `addr_o` = (segment value << 4) + offset. Segment codes are 0=data, 1=code, 2=stack, 3=extra.
- R3: The addition wraps modulo 2^20. For example, segment FFFFh plus offset FFFFh gives 0FFEFh.
- R4: Request kind 1 (instruction fetch) always uses the code segment (code 1). Any override is ignored.
- R5: Request kind 2 (stack or base pointer) uses the stack segment (code 2) when no override is valid.
- R6: Request kind 0 (general or index register data) uses the data segment (code 0) when no override is valid.
- R7: Request kind 3 (string destination) always uses the extra segment (code 3). Any override is ignored.
- R8: For kinds 0 and 2, a valid override replaces the default with the segment named by `ovr_sel_i`. `seg_used_o` reports the segment that was actually applied.
- R9: A write with `seg_we_i`=1 loads `seg_wdata_i` into the register named by `seg_wsel_i`. A request in the same cycle still uses the old value; later requests use the new one.
- R10: A cycle without a request drives `addr_valid_o` low on the next edge. In that case `addr_o` and `seg_used_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| seg_we_i | input | 1 | Segment register write enable |
| seg_wsel_i | input | 2 | Segment register to write (0 data, 1 code, 2 stack, 3 extra) |
| seg_wdata_i | input | 16 | Segment value to write |
| req_valid_i | input | 1 | Address request strobe |
| req_kind_i | input | 2 | Reference kind (0 data, 1 fetch, 2 stack, 3 string destination) |
| offset_i | input | 16 | Offset within segment |
| ovr_valid_i | input | 1 | Segment override present |
| ovr_sel_i | input | 2 | Override segment code |
| addr_valid_o | output | 1 | Registered address valid |
| addr_o | output | 20 | Physical address |
| seg_used_o | output | 2 | Code of segment applied |

## Verification
The bench builds the block with the default parameters: 16-bit segment and offset values and a shift of four, which gives a 20-bit address. These sizes make the top of the space reachable. A segment of FFFFh with an offset of FFFFh exercises the dropped carry out of bit 19. The same sizes also allow every worked segment:offset pairing and all four segment codes under each override combination. Same-cycle write-and-request ordering is driven explicitly.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  typedef enum logic [1:0] {
    SEG_DATA  = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    REF_DATA   = 2'd0,
    REF_FETCH  = 2'd1,
    REF_STACK  = 2'd2,
    REF_STRDST = 2'd3
  } ref_kind_e;

  localparam int unsigned NUM_SEG = 4;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [1:0]                    wsel_i,
  input  logic [SEG_W-1:0]              wdata_i,
  output logic [NUM_SEG-1:0][SEG_W-1:0] seg_q_o
);
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             seg_q_o[g] <= '0;
      else if (we_i && (wsel_i == 2'(g)))      seg_q_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
(
  input  logic [1:0] kind_i,
  input  logic       ovr_valid_i,
  input  logic [1:0] ovr_sel_i,
  output logic [1:0] sel_o
);
  ref_kind_e kind;
  seg_id_e   dflt;

  always_comb begin
    kind = ref_kind_e'(kind_i);
    unique case (kind)
      REF_FETCH:  dflt = SEG_CODE;
      REF_STACK:  dflt = SEG_STACK;
      REF_STRDST: dflt = SEG_EXTRA;
      default:    dflt = SEG_DATA;
    endcase
    // fetch and string destination cannot be redirected
    if (ovr_valid_i && (kind == REF_DATA || kind == REF_STACK)) sel_o = ovr_sel_i;
    else                                                        sel_o = dflt;
  end
endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned SHIFT  = 4,
  localparam int unsigned ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [SEG_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o
);
  // carry out of the top bit is discarded
  assign addr_o = {seg_i, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, off_i};
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned SHIFT  = 4,
  localparam int unsigned ADDR_W = SEG_W + SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seg_we_i,
  input  logic [1:0]        seg_wsel_i,
  input  logic [SEG_W-1:0]  seg_wdata_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [SEG_W-1:0]  offset_i,
  input  logic              ovr_valid_i,
  input  logic [1:0]        ovr_sel_i,
  output logic              addr_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        seg_used_o
);
  logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;
  logic [1:0]                    sel;
  logic [ADDR_W-1:0]             addr_d;

  seg_regfile #(.SEG_W(SEG_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (seg_we_i),
    .wsel_i  (seg_wsel_i),
    .wdata_i (seg_wdata_i),
    .seg_q_o (seg_q)
  );

  seg_select u_sel (
    .kind_i      (req_kind_i),
    .ovr_valid_i (ovr_valid_i),
    .ovr_sel_i   (ovr_sel_i),
    .sel_o       (sel)
  );

  addr_adder #(.SEG_W(SEG_W), .SHIFT(SHIFT)) u_add (
    .seg_i  (seg_q[sel]),
    .off_i  (offset_i),
    .addr_o (addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_valid_o <= 1'b0;
      addr_o       <= '0;
      seg_used_o   <= '0;
    end else begin
      addr_valid_o <= req_valid_i;
      if (req_valid_i) begin
        addr_o     <= addr_d;
        seg_used_o <= sel;
      end
    end
  end
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned SHIFT  = 4,
  localparam int unsigned ADDR_W = SEG_W + SHIFT
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        req_kind_i,
  input logic [SEG_W-1:0]  offset_i,
  input logic              ovr_valid_i,
  input logic [1:0]        ovr_sel_i,
  input logic              addr_valid_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [1:0]        seg_used_o
);
  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> addr_valid_o);
  assert_low_nibble_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> addr_o[SHIFT-1:0] == $past(offset_i[SHIFT-1:0]));
  assert_fetch_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'd1) |=> seg_used_o == 2'd1);
  assert_stack_dflt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'd2 && !ovr_valid_i) |=> seg_used_o == 2'd2);
  assert_data_dflt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'd0 && !ovr_valid_i) |=> seg_used_o == 2'd0);
  assert_strdst_extra_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'd3) |=> seg_used_o == 2'd3);
  assert_override_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ovr_valid_i && !req_kind_i[0]) |=> seg_used_o == $past(ovr_sel_i));
  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!addr_valid_o && $stable(addr_o) && $stable(seg_used_o)));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.SEG_W(SEG_W), .SHIFT(SHIFT)) u_chk (.*);

// File: tb/seg_addr_gen_test.sv
`timescale 1ns/1ps
module seg_addr_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        seg_we_i = 1'b0;
  logic [1:0]  seg_wsel_i = '0;
  logic [15:0] seg_wdata_i = '0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_kind_i = '0;
  logic [15:0] offset_i = '0;
  logic        ovr_valid_i = 1'b0;
  logic [1:0]  ovr_sel_i = '0;
  logic        addr_valid_o;
  logic [19:0] addr_o;
  logic [1:0]  seg_used_o;
  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  seg_addr_gen uut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic seg_write(logic [1:0] s, logic [15:0] v);
    @(negedge clk_i);
    seg_we_i = 1'b1; seg_wsel_i = s; seg_wdata_i = v;
    @(negedge clk_i);
    seg_we_i = 1'b0;
  endtask

  task automatic do_req(string tag, logic [1:0] kind, logic [15:0] off,
                        logic ov, logic [1:0] os,
                        logic [19:0] exp_a, logic [1:0] exp_s);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_kind_i = kind; offset_i = off;
    ovr_valid_i = ov; ovr_sel_i = os;
    @(posedge clk_i); #1;
    req_valid_i = 1'b0; ovr_valid_i = 1'b0;
    check({tag, " valid"}, 32'(addr_valid_o), 32'd1);
    check({tag, " addr"}, 32'(addr_o), 32'(exp_a));
    check({tag, " seg"}, 32'(seg_used_o), 32'(exp_s));
  endtask

  task automatic t_reset;
    #1;
    check("R1 valid in reset", 32'(addr_valid_o), 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 addr after reset", 32'(addr_o), 32'd0);
    check("R1 seg after reset", 32'(seg_used_o), 32'd0);
    // segment regs read back as zero through an address
    do_req("R1 zero seg", 2'd0, 16'h0123, 1'b0, 2'd0, 20'h00123, 2'd0);
  endtask

  task automatic t_defaults;
    seg_write(2'd0, 16'h2222);
    seg_write(2'd1, 16'h1234);
    seg_write(2'd2, 16'h9526);
    seg_write(2'd3, 16'h0014);
    do_req("R6 R2 data", 2'd0, 16'h0016, 1'b0, 2'd0, 20'h22236, 2'd0);
    do_req("R4 fetch", 2'd1, 16'h0042, 1'b0, 2'd0, 20'h12382, 2'd1);
    do_req("R5 stack", 2'd2, 16'h1800, 1'b0, 2'd0, 20'h96A60, 2'd2);
    do_req("R7 strdst", 2'd3, 16'h2020, 1'b0, 2'd0, 20'h02160, 2'd3);
  endtask

  task automatic t_override;
    do_req("R8 data->extra", 2'd0, 16'h2020, 1'b1, 2'd3, 20'h02160, 2'd3);
    do_req("R8 stack->code", 2'd2, 16'h0010, 1'b1, 2'd1, 20'h12350, 2'd1);
    do_req("R4 fetch ovr ignored", 2'd1, 16'h0042, 1'b1, 2'd3, 20'h12382, 2'd1);
    do_req("R7 strdst ovr ignored", 2'd3, 16'h2020, 1'b1, 2'd0, 20'h02160, 2'd3);
  endtask

  task automatic t_wrap;
    seg_write(2'd0, 16'hFFFF);
    do_req("R3 wrap", 2'd0, 16'hFFFF, 1'b0, 2'd0, 20'h0FFEF, 2'd0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk_i);
    seg_we_i = 1'b1; seg_wsel_i = 2'd0; seg_wdata_i = 16'h1000;
    req_valid_i = 1'b1; req_kind_i = 2'd0; offset_i = 16'h0000; ovr_valid_i = 1'b0;
    @(posedge clk_i); #1;
    seg_we_i = 1'b0; req_valid_i = 1'b0;
    check("R9 same-cycle old value", 32'(addr_o), 32'h000FFFF0);
    do_req("R9 new value", 2'd0, 16'h0000, 1'b0, 2'd0, 20'h10000, 2'd0);
  endtask

  task automatic t_idle;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R10 valid low", 32'(addr_valid_o), 32'd0);
    check("R10 addr held", 32'(addr_o), 32'h00010000);
    check("R10 seg held", 32'(seg_used_o), 32'd0);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    t_defaults();
    t_override();
    t_wrap();
    t_same_cycle();
    t_idle();
    finish_run();
  end

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule